// File: doc/BRIEF.md
# Ramped Digital Audio Attenuator

This block applies an 8-bit gain coefficient to every sample of a 16-bit stereo stream. A control interface can write the coefficient directly. It can also set a target, which the coefficient then approaches in fixed increments of 4, 8 or 16, with one increment on each rising edge of the word clock. Because the gain changes in small steps, volume changes do not produce audible clicks.

Each channel also has a separate mute stage with three settings: pass, about −12 dB, and silent. A new mute setting takes effect on a channel only at a sample near zero, so the waveform is not cut off mid-swing.

Each channel has a mute-status output. It goes high when the gain is zero and that channel has delivered a long unbroken run of zero samples. This lets the surrounding system switch off its analogue stage.

Top module: `audio_atten_ramp`

## Requirements
- R1: After reset the coefficient is 00h, `out_valid` is low, `out_l`/`out_r` are 0, both mute settings are "pass", and `mute_l`/`mute_r` are low.
- R2: Command opcode 0 writes `cmd_data` into the coefficient, and the new value is in effect from the next cycle. Any value above EEh is stored as EEh, and the same limit applies to ramp targets.
- R3: For a sample accepted with `smp_valid`, the block delivers floor(sample × coefficient / 256) one cycle later. The sample is read as two's complement, and the result is framed by a one-cycle `out_valid` pulse.
- R4: Opcodes 1, 2 and 3 set the target to `cmd_data` and select a step size of 4, 8 or 16. On every rising edge of `wclk`, the coefficient moves one step toward the target.
- R5: A step that would pass the target stops exactly on it. If there is neither a `wclk` rising edge nor a direct write, the coefficient does not change.
- R6: A new target given during a ramp takes effect from the coefficient's present value, with no jump.
- R7: Opcode 4 requests a mute setting, coded in `cmd_data[1:0]`: 00 pass, 01 −12 dB (gained result arithmetically shifted right by 2), 1x silent. Each channel adopts the request only at one of its samples whose top 7 bits are all 0 or all 1. That sample is processed with the new setting; until then the channel keeps its previous setting.
- R8: A channel's mute-status output is high when the coefficient is 00h and the channel's last 1024 accepted samples were all zero. It is low from the cycle after a nonzero sample, and also while the coefficient is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Opcode: 0 write, 1/2/3 ramp by 4/8/16, 4 mute |
| cmd_data | input | 8 | Coefficient, target or mute code |
| wclk | input | 1 | Word clock, sampled by `clk` |
| smp_valid | input | 1 | Sample pair present |
| smp_l | input | 16 | Left input sample |
| smp_r | input | 16 | Right input sample |
| out_valid | output | 1 | Result pair present |
| out_l | output | 16 | Left attenuated sample |
| out_r | output | 16 | Right attenuated sample |
| mute_l | output | 1 | Left silence status |
| mute_r | output | 1 | Right silence status |

## Verification
The coefficient cannot be read directly. The bench therefore infers it by feeding the sample 0100h, for which the gain stage returns exactly the coefficient. This gives a step-by-step view of ramps, overshoot clamping and retargeting.

The hardest condition to reach is a pending mute request that one channel has adopted and the other has not. The bench creates it by sending a zero-crossing sample on one channel while the other channel carries a large value. It then checks that each output follows its own setting.

The silence-status path needs exactly 1023 and then 1024 zero pairs. The bench sends these as one continuous valid burst.

// File: rtl/audio_atten_ramp.sv
module audio_atten_ramp #(
  parameter int DW       = 16,
  parameter int CW       = 8,
  parameter int CMAX     = 8'hEE,
  parameter int ZC_BITS  = 7,
  parameter int ZERO_RUN = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [CW-1:0] cmd_data,
  input  logic          wclk,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_l,
  input  logic [DW-1:0] smp_r,
  output logic          out_valid,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r,
  output logic          mute_l,
  output logic          mute_r
);
  localparam int ZW = $clog2(ZERO_RUN + 1);
  localparam int PW = DW + CW + 1;
  localparam logic [2:0] OP_SET  = 3'd0;
  localparam logic [2:0] OP_R4   = 3'd1;
  localparam logic [2:0] OP_R8   = 3'd2;
  localparam logic [2:0] OP_R16  = 3'd3;
  localparam logic [2:0] OP_MUTE = 3'd4;
  localparam logic [CW-1:0] LIM = CW'(CMAX);

  logic [CW-1:0] coef, tgt, step;
  logic [1:0]    mute_req;
  logic          wclk_q;
  logic          wrise;
  logic          do_set;
  logic [CW-1:0] data_lim;
  logic [CW:0]   up_sum, dn_floor;
  logic [CW-1:0] coef_nxt;

  assign wrise    = wclk & ~wclk_q;
  assign do_set   = cmd_valid && cmd_op == OP_SET;
  assign data_lim = (cmd_data > LIM) ? LIM : cmd_data;
  assign up_sum   = {1'b0, coef} + {1'b0, step};
  assign dn_floor = {1'b0, tgt} + {1'b0, step};

  always_comb begin
    coef_nxt = coef;
    if (coef < tgt)
      coef_nxt = (up_sum > {1'b0, tgt}) ? tgt : up_sum[CW-1:0];
    else if (coef > tgt)
      coef_nxt = ({1'b0, coef} < dn_floor) ? tgt : coef - step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef     <= '0;
      tgt      <= '0;
      step     <= CW'(4);
      mute_req <= 2'd0;
      wclk_q   <= 1'b0;
    end else begin
      wclk_q <= wclk;
      if (do_set) begin
        coef <= data_lim;
        tgt  <= data_lim;
      end else if (wrise) begin
        coef <= coef_nxt;
      end
      if (cmd_valid) begin
        case (cmd_op)
          OP_R4:   begin tgt <= data_lim; step <= CW'(4);  end
          OP_R8:   begin tgt <= data_lim; step <= CW'(8);  end
          OP_R16:  begin tgt <= data_lim; step <= CW'(16); end
          OP_MUTE: mute_req <= cmd_data[1:0];
          default: ;
        endcase
      end
    end
  end

  logic [DW-1:0] s_in [2];
  logic [DW-1:0] s_out [2];
  logic          silent [2];

  assign s_in[0] = smp_l;
  assign s_in[1] = smp_r;
  assign out_l   = s_out[0];
  assign out_r   = s_out[1];
  assign mute_l  = silent[0];
  assign mute_r  = silent[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= smp_valid;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [1:0]           mode_q, mode_eff;
    logic                 zc;
    logic signed [PW-1:0] prod, scaled, quarter;
    logic [ZW-1:0]        zcnt;
    logic [DW-1:0]        res;

    assign zc       = (&s_in[ch][DW-1 -: ZC_BITS]) | ~(|s_in[ch][DW-1 -: ZC_BITS]);
    assign mode_eff = zc ? mute_req : mode_q;
    assign prod     = PW'($signed(s_in[ch])) * $signed({1'b0, coef});
    assign scaled   = prod >>> CW;
    assign quarter  = scaled >>> 2;
    assign res      = (mode_eff == 2'd0) ? scaled[DW-1:0] :
                      (mode_eff == 2'd1) ? quarter[DW-1:0] : '0;
    assign silent[ch] = (coef == '0) && (zcnt == ZW'(ZERO_RUN));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q    <= 2'd0;
        s_out[ch] <= '0;
        zcnt      <= '0;
      end else if (smp_valid) begin
        mode_q    <= mode_eff;
        s_out[ch] <= res;
        if (s_in[ch] != '0)               zcnt <= '0;
        else if (zcnt != ZW'(ZERO_RUN))   zcnt <= zcnt + ZW'(1);
      end
    end
  end

  // R2
  coef_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coef <= LIM);

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !do_set |=> ((coef >= $past(coef)) ? (coef - $past(coef)) : ($past(coef) - coef)) <= CW'(16));

  // R5
  no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_set && coef <= tgt) |=> coef <= $past(tgt));

  // R5
  hold_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_set && !(wclk && !wclk_q)) |=> $stable(coef));

  // R3
  zero_gain_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && coef == '0) |=> (out_l == '0 && out_r == '0));

  // R8
  mute_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_l != '0) |=> !mute_l);
endmodule

// File: tb/audio_atten_ramp_tb.sv
`timescale 1ns/1ps
module audio_atten_ramp_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_data = '0;
  logic wclk = 1'b0, smp_valid = 1'b0;
  logic [15:0] smp_l = '0, smp_r = '0;
  logic out_valid, mute_l, mute_r;
  logic [15:0] out_l, out_r;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  audio_atten_ramp dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .wclk(wclk), .smp_valid(smp_valid), .smp_l(smp_l),
    .smp_r(smp_r), .out_valid(out_valid), .out_l(out_l), .out_r(out_r),
    .mute_l(mute_l), .mute_r(mute_r));

  // {coefficient, sample, expected}
  localparam logic [39:0] VEC [8] = '{
    {8'hEE, 16'h7FFF, 16'h76FF},
    {8'h80, 16'h1234, 16'h091A},
    {8'h80, 16'hFFFD, 16'hFFFE},
    {8'h01, 16'h8000, 16'hFF80},
    {8'h40, 16'h0101, 16'h0040},
    {8'h00, 16'h7FFF, 16'h0000},
    {8'hEE, 16'h8000, 16'h8900},
    {8'h10, 16'hFFFF, 16'hFFFF}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic probe(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk); smp_valid = 1'b1; smp_l = l; smp_r = r;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic wpulse();
    @(negedge clk); wclk = 1'b1;
    @(negedge clk); wclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic coef_is(input string req, input logic [7:0] exp);
    probe(16'h0100, 16'h0100);
    chk(req, out_l, {8'h00, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", {15'd0, out_valid}, 16'd0);
    chk("R1 out_l", out_l, 16'd0);
    chk("R1 mute_l", {15'd0, mute_l}, 16'd0);
    probe(16'h7FFF, 16'h7FFF);
    chk("R1 coef zero", out_r, 16'd0);

    // R3 vector table
    for (int i = 0; i < 8; i++) begin
      cmd(3'd0, VEC[i][39:32]);
      @(negedge clk); smp_valid = 1'b1; smp_l = VEC[i][31:16]; smp_r = VEC[i][31:16];
      @(negedge clk); smp_valid = 1'b0;
      chk("R3 out_valid", {15'd0, out_valid}, 16'd1);
      chk("R3 out_l", out_l, VEC[i][15:0]);
      chk("R3 out_r", out_r, VEC[i][15:0]);
    end

    // R2 clamp on direct write
    cmd(3'd0, 8'hFF); coef_is("R2 clamp FF", 8'hEE);
    cmd(3'd0, 8'hEF); coef_is("R2 clamp EF", 8'hEE);
    cmd(3'd0, 8'h37); coef_is("R2 direct", 8'h37);

    // R4/R5 ramps
    cmd(3'd0, 8'h10);
    cmd(3'd2, 8'h30);
    coef_is("R5 hold without wclk", 8'h10);
    wpulse(); coef_is("R4 step 8", 8'h18);
    cmd(3'd3, 8'h25);
    wpulse(); coef_is("R5 clamp up", 8'h25);
    wpulse(); coef_is("R5 stay at target", 8'h25);
    cmd(3'd1, 8'h1F);
    wpulse(); coef_is("R4 step down 4", 8'h21);
    wpulse(); coef_is("R5 clamp down", 8'h1F);

    // R6 retarget mid-ramp, R2 target clamp
    cmd(3'd0, 8'h00);
    cmd(3'd3, 8'hFF);
    wpulse(); wpulse(); wpulse();
    coef_is("R6 ramp progress", 8'h30);
    cmd(3'd3, 8'h20);
    wpulse(); coef_is("R6 retarget", 8'h20);
    cmd(3'd3, 8'hFF);
    for (int k = 0; k < 16; k++) wpulse();
    coef_is("R2 target clamp", 8'hEE);

    // R7 zero-cross gated mute
    cmd(3'd0, 8'h80);
    cmd(3'd4, 8'h01);
    probe(16'h4000, 16'h0040);
    chk("R7 L waits", out_l, 16'h2000);
    chk("R7 R adopts -12dB", out_r, 16'h0008);
    probe(16'h4000, 16'h4000);
    chk("R7 L still pass", out_l, 16'h2000);
    chk("R7 R -12dB", out_r, 16'h0800);
    probe(16'h0040, 16'h4000);
    chk("R7 L adopts -12dB", out_l, 16'h0008);
    cmd(3'd4, 8'h02);
    probe(16'h4000, 16'h4000);
    chk("R7 full waits", out_l, 16'h0800);
    probe(16'hFF80, 16'hFF80);
    chk("R7 full at zc", out_l, 16'h0000);
    probe(16'h4000, 16'h4000);
    chk("R7 full holds", out_r, 16'h0000);
    cmd(3'd4, 8'h00);
    probe(16'h4000, 16'h4000);
    chk("R7 unmute waits", out_l, 16'h0000);
    probe(16'hFFF0, 16'hFFF0);
    chk("R7 unmute at zc", out_l, 16'hFFF8);

    // R8 silence status
    cmd(3'd0, 8'h00);
    @(negedge clk); smp_valid = 1'b1; smp_l = 16'h0; smp_r = 16'h0;
    repeat (1023) @(negedge clk);
    smp_valid = 1'b0;
    chk("R8 not yet at 1023", {15'd0, mute_l}, 16'd0);
    probe(16'h0000, 16'h0000);
    chk("R8 mute_l at 1024", {15'd0, mute_l}, 16'd1);
    chk("R8 mute_r at 1024", {15'd0, mute_r}, 16'd1);
    probe(16'h0005, 16'h0000);
    chk("R8 mute_l drops", {15'd0, mute_l}, 16'd0);
    chk("R8 mute_r stays", {15'd0, mute_r}, 16'd1);
    cmd(3'd0, 8'h01);
    chk("R8 nonzero coef", {15'd0, mute_r}, 16'd0);
    cmd(3'd0, 8'h00);
    chk("R8 zero coef again", {15'd0, mute_r}, 16'd1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule